// File: doc/BRIEF.md
# Tiled Ping-Pong Dot-Product Engine

This block computes the signed integer dot product of two vectors that sit in an external word-addressed memory. A job is started with two base addresses and a length. The engine walks the vectors in tiles of `B` elements, and each tile passes through three coarse pipeline stages. The first stage fetches the tile's words of both vectors into local tile buffers. The second stage multiplies the two tiles lane by lane and folds the products into a per-tile partial sum. The third stage adds that partial sum into the job result.

Every tile buffer keeps two copies. While stage two reads one copy, stage one fills the other, so fetching tile k+1 overlaps the arithmetic on tile k. The two copies change roles only when the fetch has finished and the multiply-reduce is idle. The inner loop handles `P` elements per cycle. Each tile buffer is split into `P` banks: element j sits in bank j mod P at row j div P. The `P` products go through a balanced adder tree before they reach the per-tile accumulator.

Top module: `dotp_tiled_engine`

## Requirements
- R1: When `done` is high, `result` equals the sum over i < N of A[i]*B[i]. Elements are `DW`-bit two's-complement values, and the sum wraps modulo 2^`RW`. `result` does not change while the engine is idle and `start` is low.
- R2: Element i of vector A is read from address `base_a`+i and element i of vector B from `base_b`+i, both modulo 2^`AW`. A job issues exactly 2*N read requests.
- R3: `done` is high for exactly one cycle. In that cycle `busy` is already low and `result` holds the final value.
- R4: A start with `len` equal to zero, or with `len` not a multiple of `B` (`B` a power of two), is rejected. In the next cycle `err` is 1 and `busy` is 0. No read request follows, and `result` keeps its previous value.
- R5: `start` is ignored while `busy` is high. The running job completes with its own result and its own request count, and `err` stays 0.
- R6: In the cycle after a start is accepted, `busy` is 1, `err` is 0 and `result` is 0.
- R7: The result is correct when `mem_req_ready` is withheld on arbitrary cycles and when the response latency varies, provided responses return in request order.
- R8: With `mem_req_ready` held high and one-cycle response latency, the request port is never idle for more than 3 consecutive cycles between the first and the last request of a job, at tile boundaries included. This holds because the next tile is fetched while the previous one is reduced.
- R9: After reset, `busy`, `done`, `err` and `mem_req_valid` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Job request, sampled while idle |
| base_a | input | AW | Word address of element 0 of vector A |
| base_b | input | AW | Word address of element 0 of vector B |
| len | input | LW | Vector length N in elements |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last start was rejected for an illegal length |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | AW | Read address |
| mem_rsp_valid | input | 1 | Read data valid, in request order |
| mem_rsp_data | input | DW | Read data |
| result | output | RW | Dot-product result register |

## Verification
If a buffer copy is swapped at the wrong moment, or a bank row is mis-addressed, one tile's partial sum is corrupted. That error shows up only in `result` at `done`, so every job compares the full sum against an independently computed value, with different base addresses, lengths and memory timing. Errors in fetch or tile counting show up sooner, as a request count other than 2*N, or as `done` never arriving. A stall of the ping-pong hand-off shows up during the job as a request gap longer than three cycles at a tile boundary.

// File: rtl/dpe_pkg.sv
package dpe_pkg;
  // cyclic banking: element index -> bank and row inside the bank
  function automatic int unsigned bank_of(input int unsigned idx, input int unsigned lanes);
    return idx % lanes;
  endfunction

  function automatic int unsigned row_of(input int unsigned idx, input int unsigned lanes);
    return idx / lanes;
  endfunction
endpackage

// File: rtl/dpe_tilebuf.sv
module dpe_tilebuf #(
  parameter int DW = 16,
  parameter int B  = 16,
  parameter int P  = 2,
  localparam int ROWS = B / P,
  localparam int RAW  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int IW   = $clog2(B)
) (
  input  logic            clk,
  input  logic            we,
  input  logic            wcopy,
  input  logic [IW-1:0]   widx,
  input  logic [DW-1:0]   wdata,
  input  logic            rcopy,
  input  logic [RAW-1:0]  rrow,
  output logic [P*DW-1:0] rdata
);
  import dpe_pkg::*;

  for (genvar g = 0; g < P; g++) begin : g_bank
    logic [DW-1:0] mem [2][ROWS];
    always_ff @(posedge clk) begin
      if (we && bank_of(int'(widx), P) == g)
        mem[wcopy][RAW'(row_of(int'(widx), P))] <= wdata;
    end
    assign rdata[g*DW +: DW] = mem[rcopy][rrow];
  end
endmodule

// File: rtl/dpe_loader.sv
module dpe_loader #(
  parameter int AW = 16,
  parameter int B  = 16,
  localparam int IW = $clog2(B),
  localparam int CW = $clog2(2*B) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [AW-1:0] tile_a,
  input  logic [AW-1:0] tile_b,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  output logic          busy,
  output logic          fill_done,
  output logic          we_a,
  output logic          we_b,
  output logic [IW-1:0] widx
);
  logic [CW-1:0] issued, recvd;
  logic [AW-1:0] pa, pb;
  logic          rsp_take;

  assign req_valid = busy && (issued < CW'(2*B));
  assign req_addr  = (issued < CW'(B)) ? pa + AW'(issued) : pb + AW'(issued - CW'(B));
  assign rsp_take  = busy && rsp_valid;
  assign fill_done = rsp_take && (recvd == CW'(2*B-1));
  assign we_a      = rsp_take && (recvd <  CW'(B));
  assign we_b      = rsp_take && (recvd >= CW'(B));
  assign widx      = recvd[IW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; issued <= '0; recvd <= '0; pa <= '0; pb <= '0;
    end else if (go) begin
      busy <= 1'b1; issued <= '0; recvd <= '0; pa <= tile_a; pb <= tile_b;
    end else if (busy) begin
      if (req_valid && req_ready) issued <= issued + 1'b1;
      if (rsp_take) recvd <= recvd + 1'b1;
      if (fill_done) busy <= 1'b0;
    end
  end

  // R7: a response only ever answers a request already accepted for this tile
  a_r7_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> busy && (recvd < issued));
endmodule

// File: rtl/dpe_mac.sv
module dpe_mac #(
  parameter int DW = 16,
  parameter int B  = 16,
  parameter int P  = 2,
  parameter int RW = 48,
  localparam int ROWS = B / P,
  localparam int RAW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  output logic                 busy,
  output logic [RAW-1:0]       row,
  input  logic [P*DW-1:0]      lanes_a,
  input  logic [P*DW-1:0]      lanes_b,
  output logic                 part_valid,
  output logic signed [RW-1:0] part
);
  logic signed [RW-1:0] acc, row_sum;

  // P lane products folded by a balanced pairwise tree (P a power of two)
  function automatic logic signed [RW-1:0] tree_sum(input logic [P*DW-1:0] a,
                                                     input logic [P*DW-1:0] b);
    logic signed [RW-1:0] t [P];
    for (int i = 0; i < P; i++)
      t[i] = RW'($signed(a[i*DW +: DW])) * RW'($signed(b[i*DW +: DW]));
    for (int w = P; w > 1; w = w / 2)
      for (int i = 0; i < w / 2; i++)
        t[i] = t[2*i] + t[2*i+1];
    return t[0];
  endfunction

  assign row_sum = tree_sum(lanes_a, lanes_b);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; row <= '0; acc <= '0; part_valid <= 1'b0; part <= '0;
    end else begin
      part_valid <= 1'b0;
      if (go) begin
        busy <= 1'b1; row <= '0; acc <= '0;
      end else if (busy) begin
        if (row == RAW'(ROWS-1)) begin
          part <= acc + row_sum; part_valid <= 1'b1; busy <= 1'b0;
        end else begin
          acc <= acc + row_sum; row <= row + 1'b1;
        end
      end
    end
  end

  // R8: a new tile is never handed over while the previous one is still reducing
  a_r8_go_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
  a_r1_part_single: assert property (@(posedge clk) disable iff (!rst_n)
    part_valid |=> !part_valid);
endmodule

// File: rtl/dotp_tiled_engine.sv
module dotp_tiled_engine #(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int B  = 16,
  parameter int P  = 2,
  parameter int RW = 2*DW + LW,
  localparam int LOGB = $clog2(B),
  localparam int ROWS = B / P,
  localparam int RAW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [LW-1:0] len,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic [RW-1:0] result
);
  logic [AW-1:0] ba_q, bb_q;
  logic [LW-1:0] ntiles, ld_tiles, acc_tiles, tile_off;
  logic          wsel, rsel, loaded;
  logic          len_ok, start_acc, start_bad, swap, load_go, last_part;
  logic          ld_busy, fill_done, we_a, we_b, mac_busy, mac_pv;
  logic [LOGB-1:0]       widx;
  logic [RAW-1:0]        mac_row;
  logic [P*DW-1:0]       lanes_a, lanes_b;
  logic signed [RW-1:0]  part;

  // named control events
  assign len_ok    = (len != '0) && (len[LOGB-1:0] == '0);
  assign start_acc = start && !busy && len_ok;
  assign start_bad = start && !busy && !len_ok;
  assign swap      = busy && loaded && !mac_busy;
  assign load_go   = busy && !ld_busy && !loaded && (ld_tiles < ntiles);
  assign last_part = mac_pv && (acc_tiles == ntiles - 1'b1);
  assign tile_off  = ld_tiles << LOGB;

  dpe_loader #(.AW(AW), .B(B)) u_load (
    .clk(clk), .rst_n(rst_n), .go(load_go),
    .tile_a(ba_q + AW'(tile_off)), .tile_b(bb_q + AW'(tile_off)),
    .req_valid(mem_req_valid), .req_ready(mem_req_ready), .req_addr(mem_req_addr),
    .rsp_valid(mem_rsp_valid), .busy(ld_busy), .fill_done(fill_done),
    .we_a(we_a), .we_b(we_b), .widx(widx));

  dpe_tilebuf #(.DW(DW), .B(B), .P(P)) u_buf_a (
    .clk(clk), .we(we_a), .wcopy(wsel), .widx(widx), .wdata(mem_rsp_data),
    .rcopy(rsel), .rrow(mac_row), .rdata(lanes_a));

  dpe_tilebuf #(.DW(DW), .B(B), .P(P)) u_buf_b (
    .clk(clk), .we(we_b), .wcopy(wsel), .widx(widx), .wdata(mem_rsp_data),
    .rcopy(rsel), .rrow(mac_row), .rdata(lanes_b));

  dpe_mac #(.DW(DW), .B(B), .P(P), .RW(RW)) u_mac (
    .clk(clk), .rst_n(rst_n), .go(swap), .busy(mac_busy), .row(mac_row),
    .lanes_a(lanes_a), .lanes_b(lanes_b), .part_valid(mac_pv), .part(part));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; err <= 1'b0; result <= '0;
      ba_q <= '0; bb_q <= '0; ntiles <= '0; ld_tiles <= '0; acc_tiles <= '0;
      wsel <= 1'b0; rsel <= 1'b0; loaded <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start_acc) begin
        busy <= 1'b1; err <= 1'b0; result <= '0;
        ba_q <= base_a; bb_q <= base_b; ntiles <= len >> LOGB;
        ld_tiles <= '0; acc_tiles <= '0; wsel <= 1'b0; loaded <= 1'b0;
      end else if (start_bad) begin
        err <= 1'b1;
      end else if (busy) begin
        if (load_go) ld_tiles <= ld_tiles + 1'b1;
        if (fill_done) loaded <= 1'b1;
        if (swap) begin
          loaded <= 1'b0; rsel <= wsel; wsel <= ~wsel;
        end
        if (mac_pv) begin
          result <= result + part;
          acc_tiles <= acc_tiles + 1'b1;
          if (last_part) begin
            busy <= 1'b0; done <= 1'b1;
          end
        end
      end
    end
  end

  // R8: copies change roles only when the fetch side has let go of its copy
  a_r8_swap_loader_idle: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> !ld_busy);
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r2_req_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
  a_r4_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_bad |=> (!busy && err));
  a_r1_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
  a_r1_part_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mac_pv |-> (acc_tiles < ntiles));
endmodule

// File: tb/sim_dotp_tiled_engine.sv
module sim_dotp_tiled_engine;
  localparam int DW = 16, AW = 16, LW = 16, B = 16, P = 2, RW = 48;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] base_a = '0, base_b = '0;
  logic [LW-1:0] len = '0;
  logic busy, done, err, mem_req_valid, mem_req_ready = 1'b1;
  logic [AW-1:0] mem_req_addr;
  logic mem_rsp_valid = 1'b0;
  logic [DW-1:0] mem_rsp_data = '0;
  logic [RW-1:0] result;

  always #2.5 clk = ~clk;

  dotp_tiled_engine #(.DW(DW), .AW(AW), .LW(LW), .B(B), .P(P), .RW(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_a(base_a), .base_b(base_b),
    .len(len), .busy(busy), .done(done), .err(err), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .result(result));

  int checks = 0, errors = 0, cyc = 0;
  int mode = 0, reqcnt = 0, gap = 0, maxgap = 0;
  bit seen_req = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [AW-1:0] qa [64];
  int qt [64];
  int wp = 0, rp = 0, last_due = 0;

  // memory contents: a scrambled signed value per address
  function automatic logic signed [DW-1:0] mval(input logic [AW-1:0] a);
    logic [15:0] x;
    x = a * 16'h9E37;
    x = x ^ {a[7:0], a[15:8]} ^ 16'h5A5A;
    return x;
  endfunction

  function automatic logic [RW-1:0] exp_dot(input logic [AW-1:0] ba, input logic [AW-1:0] bb,
                                            input int n);
    logic signed [RW-1:0] s, x, y;
    s = '0;
    for (int i = 0; i < n; i++) begin
      x = mval(ba + AW'(i));
      y = mval(bb + AW'(i));
      s = s + x * y;
    end
    return s;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model: ready first, then the handshake it implies, then an in-order response
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    mem_req_ready = (mode == 1) ? lfsr[0] : 1'b1;
    if (busy) begin
      if (mem_req_valid) begin
        if (seen_req && gap > maxgap) maxgap = gap;
        gap = 0; seen_req = 1;
      end else gap++;
    end
    if (mem_req_valid && mem_req_ready) begin
      int lat;
      lat = (mode == 0) ? 1 : (mode == 1) ? 1 + int'(lfsr[3:2]) : 6;
      qa[wp] = mem_req_addr;
      qt[wp] = (cyc + lat > last_due) ? cyc + lat : last_due + 1;
      last_due = qt[wp];
      wp = (wp + 1) % 64;
      reqcnt++;
    end
    if (rp != wp && qt[rp] <= cyc) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data = mval(qa[rp]);
      rp = (rp + 1) % 64;
    end else begin
      mem_rsp_valid = 1'b0;
    end
    if (cyc == 150000) begin
      chk(0, "watchdog", 64'(cyc), 64'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic run_job(input logic [AW-1:0] ba, input logic [AW-1:0] bb, input int n,
                         input int md, input bit exp_err);
    logic [RW-1:0] prev, expv;
    string tg;
    prev = result;
    @(negedge clk);
    mode = md; base_a = ba; base_b = bb; len = LW'(n); start = 1'b1;
    reqcnt = 0; seen_req = 0; gap = 0; maxgap = 0;
    @(negedge clk);
    start = 1'b0;
    if (exp_err) begin
      chk(err == 1'b1 && busy == 1'b0, "R4 reject flags", {62'd0, err, busy}, 64'd2);
      repeat (6) @(negedge clk);
      chk(reqcnt == 0, "R4 no requests", 64'(reqcnt), 64'd0);
      chk(result == prev, "R4 result kept", 64'(result), 64'(prev));
    end else begin
      chk(busy && !err && result == '0, "R6 accept state", 64'(result), 64'd0);
      while (!done) @(negedge clk);
      expv = exp_dot(ba, bb, n);
      tg = (md == 0) ? "R1 dot product" : "R7 dot product under stalls";
      chk(result == expv, tg, 64'(result), 64'(expv));
      chk(!busy, "R3 busy low at done", 64'(busy), 64'd0);
      chk(reqcnt == 2*n, "R2 request count", 64'(reqcnt), 64'(2*n));
      @(negedge clk);
      chk(!done, "R3 done single cycle", 64'(done), 64'd0);
    end
  endtask

  // {base_a, base_b, len, memory mode, expect reject}
  localparam logic [50:0] VEC [8] = '{
    {16'h0000, 16'h0100, 16'd16,  2'd0, 1'b0},
    {16'h0040, 16'h8000, 16'd64,  2'd1, 1'b0},
    {16'hFFF0, 16'h1234, 16'd32,  2'd2, 1'b0},
    {16'h0200, 16'h0300, 16'd10,  2'd0, 1'b1},
    {16'h0000, 16'h0000, 16'd0,   2'd0, 1'b1},
    {16'h0500, 16'h0500, 16'd48,  2'd1, 1'b0},
    {16'h7000, 16'h7100, 16'd128, 2'd0, 1'b0},
    {16'h0010, 16'h0020, 16'd24,  2'd2, 1'b1}
  };

  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk(!busy && !done && !err && !mem_req_valid && result == '0, "R9 reset state",
        {59'd0, busy, done, err, mem_req_valid, |result}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 8; k++)
      run_job(VEC[k][50:35], VEC[k][34:19], int'(VEC[k][18:3]), int'(VEC[k][2:1]), VEC[k][0]);

    // R8: tile fetches overlap the reduction
    run_job(16'h0300, 16'h0900, 64, 0, 1'b0);
    chk(maxgap <= 3, "R8 request gap", 64'(maxgap), 64'd3);

    // R5: a second start during a job is ignored
    @(negedge clk);
    mode = 0; base_a = 16'h1000; base_b = 16'h2000; len = 16'd32; start = 1'b1; reqcnt = 0;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    base_a = 16'h4444; base_b = 16'h5555; len = 16'd16; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!err, "R5 no error on ignored start", 64'(err), 64'd0);
    while (!done) @(negedge clk);
    chk(result == exp_dot(16'h1000, 16'h2000, 32), "R5 original job result",
        64'(result), 64'(exp_dot(16'h1000, 16'h2000, 32)));
    chk(reqcnt == 64, "R5 original request count", 64'(reqcnt), 64'd64);

    // R6: a good start after a rejected one clears err and result
    run_job(16'h0000, 16'h0000, 5, 0, 1'b1);
    run_job(16'h0abc, 16'h0def, 16, 0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule